// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into one asynchronous serial frame on a single output line. It takes the character through a valid/ready handshake, together with a set of format inputs that are sampled at the moment of acceptance. A one-cycle bit-rate enable from an external divider paces the frame; each enable starts the next bit. Between frames the line rests at the mark (inactive) level.

The format inputs cover the character length (7, 8 or 9 bits), the bit order, the parity rule, the number of stop bits and the polarity of the line. In 9-bit mode the top bit is an extension bit. It always follows the eight data bits, whichever order was chosen for them. A `busy` output shows that a frame is accepted or in flight.

Top module: `uart_frame_tx`

## Requirements
- R1: Every frame opens with exactly one start bit at the space level (0 before inversion). It begins at the first `bit_tick` after acceptance and never in the acceptance cycle itself.
- R2: `char_ready` is high only when no frame is pending or in flight. A character is taken when `char_valid` and `char_ready` are both high at a clock edge. From the next cycle `busy` is high and `char_ready` is low until the frame ends. `char_valid` held high while busy takes nothing.
- R3: `fmt_len` selects the character length: 0 gives 7 bits, 2 gives 9 bits, and 1 or 3 give 8 bits. With `fmt_msb_first` = 0, data bits go out from bit 0 upward. With `fmt_msb_first` = 1, they go from the highest data bit (bit 6 for 7-bit, bit 7 otherwise) downward.
- R4: In 9-bit mode, bit 8 of `char_data` is sent right after the eight data bits, in both orders. For example, 0x155 LSB-first with even parity and one stop bit gives 0,1,0,1,0,1,0,1,0,1,1,1. MSB-first it gives 0,0,1,0,1,0,1,0,1,1,1,1.
- R5: `fmt_parity` selects the parity bit, which follows the last character bit: 0 means no parity bit, 1 even, 2 odd, and 3 a constant 0. Even and odd parity are taken over all character bits, including the extension bit.
- R6: `fmt_two_stop` = 0 sends one stop bit at the mark level and 1 sends two. After the last stop bit the line returns to the mark level and `busy` falls at the next `bit_tick`.
- R7: `fmt_invert` = 1 flips every level on `txd`. While idle the live input sets the polarity, so the idle level of `txd` is the inverse of `fmt_invert`. During a frame the value sampled at acceptance is used.
- R8: The character and all format inputs are sampled only at acceptance. Changing them while a frame is pending or in flight does not change that frame.
- R9: Each bit of a frame lasts exactly one `bit_tick` period, including when the ticks come on every cycle. Out of reset the line is at the mark level, `busy` is low and `char_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle bit-rate enable |
| char_valid | input | 1 | Character offered |
| char_ready | output | 1 | Block is idle and will take a character |
| char_data | input | 9 | Character; bit 8 is the extension bit in 9-bit mode |
| fmt_len | input | 2 | Character length select (0:7, 2:9, otherwise 8) |
| fmt_parity | input | 2 | Parity rule (0 none, 1 even, 2 odd, 3 zero) |
| fmt_two_stop | input | 1 | Two stop bits when high |
| fmt_msb_first | input | 1 | Highest data bit first when high |
| fmt_invert | input | 1 | Invert the line polarity when high |
| txd | output | 1 | Serial output |
| busy | output | 1 | Frame pending or in flight |

## Verification
The bench builds the block with its package defaults: a 9-bit character and a 13-bit longest frame. The tick spacing changes during the run, down to a tick on every cycle. This makes it possible for an acceptance to land on a tick, for a tick to follow acceptance at once, and for frames to run back to back with a held `char_valid`. A sweep over every length, parity, stop-bit and order combination, with inversion and mid-frame input changes mixed in, reaches each field position of the longest and shortest frames.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
  localparam int CHAR_MAX  = 9;
  localparam int DATA_MAX  = CHAR_MAX - 1;
  localparam int FRAME_MAX = 1 + CHAR_MAX + 1 + 2;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {PAR_NONE, PAR_EVEN, PAR_ODD, PAR_ZERO} par_e;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} tx_state_e;

  typedef struct packed {
    logic [FRAME_MAX-1:0] bits;   // bit 0 goes out first
    logic [CNT_W-1:0]     nbits;
  } frame_t;

  // number of ordinary data bits for a length code
  function automatic logic [3:0] data_count(input logic [1:0] len);
    return (len == 2'd0) ? 4'd7 : 4'd8;
  endfunction

  function automatic logic has_ext(input logic [1:0] len);
    return len == 2'd2;
  endfunction

  function automatic logic [CHAR_MAX-1:0] char_mask(input logic [1:0] len);
    logic [CHAR_MAX-1:0] m;
    case (len)
      2'd0:    m = 9'h07F;
      2'd2:    m = 9'h1FF;
      default: m = 9'h0FF;
    endcase
    return m;
  endfunction

  function automatic logic parity_bit(input logic [CHAR_MAX-1:0] chr,
                                      input logic [1:0] len, input par_e par);
    logic odd_ones;
    odd_ones = ^(chr & char_mask(len));
    case (par)
      PAR_EVEN: return odd_ones;
      PAR_ODD:  return ~odd_ones;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic frame_t build_frame(input logic [CHAR_MAX-1:0] chr,
                                         input logic [1:0] len, input par_e par,
                                         input logic two_stop, input logic msb);
    frame_t f;
    logic [CNT_W-1:0] pos;
    logic [3:0] nd;
    logic [3:0] src;
    f.bits = '1;
    nd = data_count(len);
    f.bits[0] = 1'b0;
    pos = CNT_W'(1);
    for (int k = 0; k < DATA_MAX; k++) begin
      if (4'(k) < nd) begin
        src = msb ? (nd - 4'd1 - 4'(k)) : 4'(k);
        f.bits[pos] = chr[src];
        pos = pos + 1'b1;
      end
    end
    if (has_ext(len)) begin
      f.bits[pos] = chr[CHAR_MAX-1];
      pos = pos + 1'b1;
    end
    if (par != PAR_NONE) begin
      f.bits[pos] = parity_bit(chr, len, par);
      pos = pos + 1'b1;
    end
    f.bits[pos] = 1'b1;
    pos = pos + 1'b1;
    if (two_stop) begin
      f.bits[pos] = 1'b1;
      pos = pos + 1'b1;
    end
    f.nbits = pos;
    return f;
  endfunction
endpackage

// File: rtl/uftx_framer.sv
module uftx_framer
  import uftx_pkg::*;
(
  input  logic [CHAR_MAX-1:0] chr,
  input  logic [1:0]          len,
  input  logic [1:0]          par,
  input  logic                two_stop,
  input  logic                msb,
  output frame_t              frame
);
  always_comb frame = build_frame(chr, len, par_e'(par), two_stop, msb);
endmodule

// File: rtl/uftx_serializer.sv
module uftx_serializer
  import uftx_pkg::*;
#(
  parameter int FW = FRAME_MAX,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [FW-1:0] frame_bits,
  input  logic [CW-1:0] frame_len,
  input  logic          inv_in,
  output logic          line_raw,
  output logic          inv_q,
  output logic          busy,
  output logic          ev_start,
  output logic          ev_end,
  output logic [FW-1:0] sh_q
);
  tx_state_e     state;
  logic [CW-1:0] cnt;
  logic          shift_now;

  assign ev_start  = (state == S_WAIT) && tick;
  assign ev_end    = (state == S_SEND) && tick && (cnt == '0);
  assign shift_now = ev_start || ((state == S_SEND) && tick && (cnt != '0));
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sh_q     <= '1;
      cnt      <= '0;
      line_raw <= 1'b1;
      inv_q    <= 1'b0;
    end else if (state == S_IDLE) begin
      if (load) begin
        sh_q  <= frame_bits;
        cnt   <= frame_len;
        inv_q <= inv_in;
        state <= S_WAIT;
      end
    end else if (shift_now) begin
      line_raw <= sh_q[0];
      sh_q     <= {1'b1, sh_q[FW-1:1]};
      cnt      <= cnt - 1'b1;
      state    <= S_SEND;
    end else if (ev_end) begin
      line_raw <= 1'b1;
      state    <= S_IDLE;
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                char_valid,
  output logic                char_ready,
  input  logic [CHAR_MAX-1:0] char_data,
  input  logic [1:0]          fmt_len,
  input  logic [1:0]          fmt_parity,
  input  logic                fmt_two_stop,
  input  logic                fmt_msb_first,
  input  logic                fmt_invert,
  output logic                txd,
  output logic                busy
);
  frame_t               frame;
  logic                 accept;
  logic                 line_raw;
  logic                 inv_q;
  logic                 ev_start;
  logic                 ev_end;
  logic [FRAME_MAX-1:0] sh_q;

  uftx_framer u_framer (
    .chr      (char_data),
    .len      (fmt_len),
    .par      (fmt_parity),
    .two_stop (fmt_two_stop),
    .msb      (fmt_msb_first),
    .frame    (frame)
  );

  assign accept     = char_valid && char_ready;
  assign char_ready = !busy;

  uftx_serializer u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (bit_tick),
    .load       (accept),
    .frame_bits (frame.bits),
    .frame_len  (frame.nbits),
    .inv_in     (fmt_invert),
    .line_raw   (line_raw),
    .inv_q      (inv_q),
    .busy       (busy),
    .ev_start   (ev_start),
    .ev_end     (ev_end),
    .sh_q       (sh_q)
  );

  assign txd = line_raw ^ (busy ? inv_q : fmt_invert);
endmodule

// File: rtl/uftx_checker.sv
module uftx_checker
  import uftx_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bit_tick,
  input logic                 char_ready,
  input logic                 busy,
  input logic                 txd,
  input logic                 fmt_invert,
  input logic                 accept,
  input logic                 ev_start,
  input logic                 ev_end,
  input logic                 line_raw,
  input logic [FRAME_MAX-1:0] sh_q
);
  assert_accept_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !char_ready));

  assert_start_space_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !line_raw);

  assert_no_start_on_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> line_raw);

  assert_bit_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(line_raw));

  assert_frame_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> $stable(sh_q));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd == !fmt_invert));

  assert_last_stop_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |-> line_raw);

  assert_end_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> (!busy && line_raw));
endmodule

bind uart_frame_tx uftx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_tick   (bit_tick),
  .char_ready (char_ready),
  .busy       (busy),
  .txd        (txd),
  .fmt_invert (fmt_invert),
  .accept     (accept),
  .ev_start   (ev_start),
  .ev_end     (ev_end),
  .line_raw   (line_raw),
  .sh_q       (sh_q)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       char_valid = 1'b0;
  logic [8:0] char_data = '0;
  logic [1:0] fmt_len = 2'd1;
  logic [1:0] fmt_parity = 2'd0;
  logic       fmt_two_stop = 1'b0;
  logic       fmt_msb_first = 1'b0;
  logic       fmt_invert = 1'b0;
  wire        char_ready;
  wire        txd;
  wire        busy;

  uart_frame_tx u_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .char_valid(char_valid), .char_ready(char_ready), .char_data(char_data),
    .fmt_len(fmt_len), .fmt_parity(fmt_parity), .fmt_two_stop(fmt_two_stop),
    .fmt_msb_first(fmt_msb_first), .fmt_invert(fmt_invert),
    .txd(txd), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int tick_div = 4;
  int cyc = 0;
  bit done = 0;

  // reference model state: 0 idle, 1 waiting for first tick, 2 sending
  int m_state = 0;
  int m_line = 1;
  int m_tag = 9;
  int m_inv = 0;
  int bq[$];
  int tq[$];
  int cap[$];
  bit tick_seen = 0;
  bit busy_prev = 0;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // expected frame from the requirements (tags: 1 start, 3 data, 4 ext, 5 parity, 6 stop)
  task automatic model_load(input logic [8:0] d, input logic [1:0] len, input logic [1:0] par,
                            input logic st, input logic msb);
    int nd;
    int ones;
    bq.delete(); tq.delete();
    bq.push_back(0); tq.push_back(1);
    nd = (len == 2'd0) ? 7 : 8;
    if (msb) for (int k = nd - 1; k >= 0; k--) begin bq.push_back(int'(d[k])); tq.push_back(3); end
    else     for (int k = 0; k < nd; k++)      begin bq.push_back(int'(d[k])); tq.push_back(3); end
    ones = 0;
    for (int k = 0; k < nd; k++) ones += int'(d[k]);
    if (len == 2'd2) begin bq.push_back(int'(d[8])); tq.push_back(4); ones += int'(d[8]); end
    case (par)
      2'd1: begin bq.push_back(ones % 2);     tq.push_back(5); end
      2'd2: begin bq.push_back(1 - ones % 2); tq.push_back(5); end
      2'd3: begin bq.push_back(0);            tq.push_back(5); end
      default: ;
    endcase
    bq.push_back(1); tq.push_back(6);
    if (st) begin bq.push_back(1); tq.push_back(6); end
  endtask

  always @(negedge clk) begin
    cyc++;
    bit_tick = (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
  end

  always @(posedge clk) begin
    tick_seen = bit_tick;
    if (!rst_n) begin
      m_state = 0; m_line = 1; m_tag = 9; m_inv = 0;
    end else if (m_state == 0) begin
      if (char_valid) begin
        model_load(char_data, fmt_len, fmt_parity, fmt_two_stop, fmt_msb_first);
        m_inv = int'(fmt_invert);
        m_state = 1;
      end
    end else if (bit_tick) begin
      if (bq.size() > 0) begin
        m_line = bq.pop_front(); m_tag = tq.pop_front(); m_state = 2;
      end else begin
        m_line = 1; m_tag = 9; m_state = 0;
      end
    end
  end

  // compare a quarter period after the falling edge, when inputs have settled
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      int exp_txd;
      int tag;
      exp_txd = m_line ^ ((m_state == 0) ? int'(fmt_invert) : m_inv);
      tag = (m_state == 0) ? ((fmt_invert) ? 7 : 9) : ((m_inv != 0) ? 7 : m_tag);
      chk($sformatf("R%0d", tag), "txd", 16'(txd), 16'(exp_txd));
      chk("R2", "char_ready", 16'(char_ready), 16'(m_state == 0));
      chk("R2", "busy", 16'(busy), 16'(m_state != 0));
      if (tick_seen && busy && busy_prev) cap.push_back(int'(txd));
      busy_prev = busy;
    end
  end

  task automatic send(input logic [8:0] d, input logic [1:0] len, input logic [1:0] par,
                      input logic st, input logic msb, input logic inv, input bit scramble);
    @(negedge clk);
    while (m_state != 0) @(negedge clk);
    char_data = d; fmt_len = len; fmt_parity = par;
    fmt_two_stop = st; fmt_msb_first = msb; fmt_invert = inv;
    char_valid = 1'b1;
    cap.delete();
    @(negedge clk);
    char_valid = 1'b0;
    if (scramble) begin
      // R8: disturb every sampled input while the frame is in flight
      char_data = ~d; fmt_len = ~len; fmt_parity = ~par;
      fmt_two_stop = ~st; fmt_msb_first = ~msb; fmt_invert = ~inv;
    end
    while (m_state != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_capture(input int exp_bits[12], input string what);
    chk("R9", {what, " bit count"}, 16'(cap.size()), 16'd12);
    for (int i = 0; i < 12; i++) begin
      string req;
      req = (i == 0) ? "R1" : (i <= 8) ? "R3" : (i == 9) ? "R4" : (i == 10) ? "R5" : "R6";
      if (i < cap.size()) chk(req, $sformatf("%s bit %0d", what, i), 16'(cap[i]), 16'(exp_bits[i]));
    end
  endtask

  initial begin
    int lsb_exp[12] = '{0,1,0,1,0,1,0,1,0,1,1,1};
    int msb_exp[12] = '{0,0,1,0,1,0,1,0,1,1,1,1};
    int idx;
    repeat (4) @(negedge clk);
    #(CLK_PERIOD/4);
    chk("R9", "reset txd", 16'(txd), 16'd1);
    chk("R9", "reset busy", 16'(busy), 16'd0);
    chk("R2", "reset char_ready", 16'(char_ready), 16'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R4 0x155 LSB-first, even parity, one stop
    send(9'h155, 2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 0);
    check_capture(lsb_exp, "R4 lsb 0x155");
    // R4 0x155 MSB-first
    send(9'h155, 2'd2, 2'd1, 1'b0, 1'b1, 1'b0, 0);
    check_capture(msb_exp, "R4 msb 0x155");

    // R9 tick on every cycle, 7-bit odd parity two stops
    tick_div = 1;
    send(9'h05A, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 0);
    // R7 inverted line with R5 zero parity, R8 inputs disturbed mid-frame
    tick_div = 3;
    send(9'h0A5, 2'd1, 2'd3, 1'b0, 1'b1, 1'b1, 1);
    send(9'h10F, 2'd3, 2'd0, 1'b1, 1'b0, 1'b0, 0);

    // R2 char_valid held high across frames: exactly one acceptance per idle window
    tick_div = 2;
    @(negedge clk);
    char_data = 9'h0C3; fmt_len = 2'd1; fmt_parity = 2'd1; fmt_two_stop = 1'b0;
    fmt_msb_first = 1'b0; fmt_invert = 1'b0;
    char_valid = 1'b1;
    @(negedge clk);
    while (m_state != 0) @(negedge clk);
    @(negedge clk);
    char_valid = 1'b0;
    while (m_state != 0) @(negedge clk);

    // R3 R5 R6 sweep of every format combination
    idx = 0;
    for (int len = 0; len < 3; len++)
      for (int par = 0; par < 4; par++)
        for (int st = 0; st < 2; st++)
          for (int msb = 0; msb < 2; msb++) begin
            tick_div = 1 + idx % 5;
            send(9'((idx * 151 + 37) % 512), 2'(len), 2'(par), 1'(st), 1'(msb),
                 1'(idx % 5 == 0), (idx % 3) == 0);
            idx++;
          end

    repeat (8) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    done = 1;
    n_checks++;
    n_errors++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule